// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block runs through a ring of transmit buffer descriptors held in memory. It gathers the data buffers of ready descriptors into frames and sends each finished frame out on a byte stream. A start strobe begins a walk at a saved descriptor pointer. The walk follows each descriptor either to the next slot or back to the ring base. It ends when the next address would be the ring base. At that point it stores the final pointer and raises a halt flag for its ring.

Frame-wide options come from the first descriptor that carries data: zero padding up to a minimum length, and dropping a leading offload header of 8 bytes. Completion events come from the descriptor that ends the frame. Each processed descriptor has its flags halfword written back. The written value clears ownership and the transmit-status bits and keeps the software control bits. Memory is byte-wide with a read latency of one cycle. A descriptor's bytes can be read in either byte order.

Top module: `tx_ring_walker`

## Requirements
- R1: A descriptor is 8 bytes. Bytes 0-1 hold the flags, bytes 2-3 the length and bytes 4-7 the buffer pointer. When `desc_le` is 1 the lowest-addressed byte of each field is its least significant byte. When it is 0 that byte is the most significant.
- R2: The low 3 bits of `ring_base` and `cur_ptr` are treated as zero.
- R3: A `start` with `tx_en` low performs no memory access. It leaves `ptr_we` low and `halt_flags` unchanged.
- R4: The walk begins at the aligned current pointer. After each descriptor it moves to the ring base if flag bit 13 (wrap) is set, and to the address plus 8 otherwise. It stops when that next address equals the ring base.
- R5: A descriptor whose flag bit 15 (ready) is clear contributes no data and is not written back.
- R6: The buffers of ready descriptors are appended in walk order. A buffer's byte i is read at {`addr_hi`, pointer} + i. A zero-length descriptor adds no bytes.
- R7: Frame options come from the frame's first descriptor with nonzero length: bit 14 (pad) and bit 1 (offload header).
- R8: A ready descriptor with bit 11 (last) set ends the frame if the frame holds bytes, and the frame is sent. If the pad option or `pad_all` is set, zeros extend it to 64 bytes. If the offload option is set, the first 8 bytes are not sent. `tx_last` marks the final byte, and data holds steady while `tx_ready` is low.
- R9: A ready descriptor with bit 12 (interrupt) set pulses `frame_done` for one cycle if it ended a frame, and `buf_done` otherwise.
- R10: Write-back stores the flags with bits 15, 9, 8, 7, 5:2, 1 and 0 cleared and all other bits kept, in the byte order of R1. Length and pointer bytes are left untouched.
- R11: At the end of a walk, `ptr_out` takes the final address with a one-cycle `ptr_we` pulse, and bit 31-RING_ID of `halt_flags` is set. An accepted start clears `halt_flags`.
- R12: After a frame ends, the accumulated length restarts at zero. A later frame in the same walk latches its own first-descriptor options.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a ring walk when idle |
| tx_en | input | 1 | MAC transmit enable |
| pad_all | input | 1 | Global pad-to-minimum enable |
| desc_le | input | 1 | Descriptor byte order, 1 = little-endian |
| ring_base | input | 32 | Ring base address |
| cur_ptr | input | 32 | Saved current descriptor pointer |
| addr_hi | input | HI_W | Upper address bits for buffer reads |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | HI_W+32 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte valid |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Sink accepts byte |
| frame_done | output | 1 | Frame-done event pulse |
| buf_done | output | 1 | Buffer-done event pulse |
| ptr_we | output | 1 | Pointer store pulse at end of walk |
| ptr_out | output | 32 | Final descriptor pointer |
| halt_flags | output | 32 | Ring halt status bits |

## Verification
Results of a walk appear at different times. A frame byte is committed at the clock edge where `tx_valid` and `tx_ready` are both high. An event pulse appears in the first write-back cycle of its descriptor. `ptr_we`, `ptr_out` and the halt bit appear one cycle after the final descriptor's next address is computed, after all write-backs. The bench samples the stream and pulses on falling edges, so each one-cycle pulse is counted exactly once. It checks memory, pointer and halt state only after it has seen `ptr_we`. By then every write-back of the walk has landed.

// File: rtl/tx_ring_walker.sv
module tx_ring_walker #(
  parameter int RING_ID     = 0,
  parameter int MIN_FRAME   = 64,
  parameter int FRAME_MAX   = 128,
  parameter int OFFLOAD_HDR = 8,
  parameter int HI_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tx_en,
  input  logic              pad_all,
  input  logic              desc_le,
  input  logic [31:0]       ring_base,
  input  logic [31:0]       cur_ptr,
  input  logic [HI_W-1:0]   addr_hi,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [HI_W+31:0]  mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              frame_done,
  output logic              buf_done,
  output logic              ptr_we,
  output logic [31:0]       ptr_out,
  output logic [31:0]       halt_flags
);
  localparam int AW = HI_W + 32;
  localparam int IW = $clog2(FRAME_MAX);
  localparam logic [15:0] KEEP = 16'h7C40;
  localparam int F_RDY = 15, F_PAD = 14, F_WRAP = 13, F_IRQ = 12, F_LAST = 11, F_OFF = 1;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_DEC, S_COPY, S_END, S_EMIT, S_WB, S_NEXT} st_t;
  st_t state;

  logic [31:0] base, daddr, nxt;
  logic [63:0] desc;
  logic [15:0] cnt, acc, dlen, oidx, olen, first_fl, fl, ln, hdr, plen;
  logic [31:0] bp;
  logic        rd_q, ends_frame, pad_on;
  logic [7:0]  frame [FRAME_MAX];
  logic [7:0]  b [8];
  logic [15:0] newfl;

  always_comb
    for (int k = 0; k < 8; k++) b[k] = desc[63-8*k -: 8];

  assign fl     = desc_le ? {b[1], b[0]} : {b[0], b[1]};
  assign ln     = desc_le ? {b[3], b[2]} : {b[2], b[3]};
  assign bp     = desc_le ? {b[7], b[6], b[5], b[4]} : {b[4], b[5], b[6], b[7]};
  assign nxt    = fl[F_WRAP] ? base : daddr + 32'd8;
  assign pad_on = first_fl[F_PAD] | pad_all;
  assign hdr    = first_fl[F_OFF] ? 16'(OFFLOAD_HDR) : 16'd0;
  assign plen   = (pad_on && acc < 16'(MIN_FRAME)) ? 16'(MIN_FRAME) : acc;
  assign newfl  = fl & KEEP;

  assign mem_rd    = (state == S_RD && cnt < 16'd8) || (state == S_COPY && cnt < ln);
  assign mem_wr    = (state == S_WB);
  assign mem_addr  = (state == S_COPY) ? {addr_hi, bp} + AW'(cnt) : {{HI_W{1'b0}}, daddr + 32'(cnt)};
  assign mem_wdata = (cnt[0] ^ desc_le) ? newfl[7:0] : newfl[15:8];

  assign tx_valid   = (state == S_EMIT);
  assign tx_last    = tx_valid && (oidx == olen - 16'd1);
  assign tx_data    = (oidx < dlen && oidx < 16'(FRAME_MAX)) ? frame[oidx[IW-1:0]] : 8'h00;
  assign frame_done = (state == S_WB) && cnt == 16'd0 && fl[F_IRQ] && ends_frame;
  assign buf_done   = (state == S_WB) && cnt == 16'd0 && fl[F_IRQ] && !ends_frame;

  always_ff @(posedge clk)
    if (state == S_COPY && rd_q && acc < 16'(FRAME_MAX)) frame[acc[IW-1:0]] <= mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; base <= '0; daddr <= '0; desc <= '0; cnt <= '0; rd_q <= 1'b0;
      acc <= '0; dlen <= '0; oidx <= '0; olen <= '0; first_fl <= '0; ends_frame <= 1'b0;
      ptr_we <= 1'b0; ptr_out <= '0; halt_flags <= '0;
    end else begin
      rd_q   <= mem_rd;
      ptr_we <= 1'b0;
      case (state)
        S_IDLE: if (start && tx_en) begin
          base <= {ring_base[31:3], 3'b000};
          daddr <= {cur_ptr[31:3], 3'b000};
          halt_flags <= '0;
          cnt <= '0;
          state <= S_RD;
        end
        S_RD: begin
          if (rd_q) desc <= {desc[55:0], mem_rdata};
          if (cnt == 16'd8) state <= S_DEC;
          else cnt <= cnt + 16'd1;
        end
        S_DEC: begin
          cnt <= '0;
          if (!fl[F_RDY]) state <= S_NEXT;
          else begin
            if (ln != 16'd0 && acc == 16'd0) first_fl <= fl;
            state <= (ln != 16'd0) ? S_COPY : S_END;
          end
        end
        S_COPY: begin
          if (rd_q) acc <= acc + 16'd1;
          if (cnt < ln) cnt <= cnt + 16'd1;
          else if (!rd_q) state <= S_END;
        end
        S_END: begin
          ends_frame <= fl[F_LAST] && acc != 16'd0;
          cnt <= '0;
          state <= S_WB;
          if (fl[F_LAST] && acc != 16'd0) begin
            dlen <= acc;
            acc <= '0;
            oidx <= hdr;
            olen <= plen;
            if (tx_en && plen > hdr) state <= S_EMIT;
          end
        end
        S_EMIT: if (tx_ready) begin
          if (tx_last) state <= S_WB;
          else oidx <= oidx + 16'd1;
        end
        S_WB: begin
          if (cnt == 16'd1) state <= S_NEXT;
          cnt <= cnt + 16'd1;
        end
        S_NEXT: begin
          cnt <= '0;
          if (nxt == base) begin
            ptr_out <= nxt;
            ptr_we <= 1'b1;
            halt_flags[31-RING_ID] <= 1'b1;
            state <= S_IDLE;
          end else begin
            daddr <= nxt;
            state <= S_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r8_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  a_r8_stream_stops_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> !tx_valid);
  a_r3_disabled_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE && start && !tx_en |=> !mem_rd && !mem_wr);
  a_r11_halt_with_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |-> halt_flags[31-RING_ID] && ptr_out[2:0] == 3'b000);
  a_r10_ready_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && (mem_addr[0] == desc_le) |-> !mem_wdata[7]);
  a_r2_desc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_RD && mem_rd && cnt == 16'd0 |-> mem_addr[2:0] == 3'b000);
endmodule

// File: tb/test_tx_ring_walker.sv
module test_tx_ring_walker;
  localparam int RID = 2;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tx_en = 1'b0, pad_all = 1'b0, desc_le = 1'b0;
  logic [31:0] ring_base = '0, cur_ptr = '0;
  logic [3:0] addr_hi = '0;
  logic mem_rd, mem_wr, tx_valid, tx_last, frame_done, buf_done, ptr_we;
  logic [35:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, tx_data;
  logic tx_ready = 1'b0;
  logic [31:0] ptr_out, halt_flags;

  tx_ring_walker #(.RING_ID(RID)) i_tx_ring_walker (.*);

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [7:0] dmem [512];
  logic tb_we = 1'b0;
  logic [8:0] tb_a = '0;
  logic [7:0] tb_d = '0;
  logic [35:0] moff;
  assign moff = mem_addr - 36'h100;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (tb_we) dmem[tb_a] <= tb_d;
    if (mem_wr && mem_addr >= 36'h100 && mem_addr < 36'h300) dmem[moff[8:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= (mem_addr >= 36'h100 && mem_addr < 36'h300) ? dmem[moff[8:0]] : pat(mem_addr[15:0]);
  end

  int rc = 0;
  always @(posedge clk) begin
    rc <= rc + 1;
    tx_ready <= (rc % 3) != 0;
  end

  logic [7:0] obuf [1024];
  int ocnt = 0, nfr = 0, nfd = 0, nbd = 0, nrd = 0, npw = 0;
  int fend [64];
  logic [3:0] hi_seen = '0;
  always @(negedge clk) if (rst_n) begin
    if (tx_valid && tx_ready) begin
      obuf[ocnt] = tx_data;
      ocnt++;
      if (tx_last) begin fend[nfr] = ocnt; nfr++; end
    end
    if (frame_done) nfd++;
    if (buf_done) nbd++;
    if (mem_rd) nrd++;
    if (mem_rd && mem_addr[35:32] != 4'h0) hi_seen = mem_addr[35:32];
    if (ptr_we) npw++;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put_byte(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_a = 9'(a - 32'h100); tb_d = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [15:0] f, input logic [15:0] l,
                          input logic [31:0] p, input bit le);
    if (le) begin
      put_byte(a, f[7:0]); put_byte(a+1, f[15:8]); put_byte(a+2, l[7:0]); put_byte(a+3, l[15:8]);
      put_byte(a+4, p[7:0]); put_byte(a+5, p[15:8]); put_byte(a+6, p[23:16]); put_byte(a+7, p[31:24]);
    end else begin
      put_byte(a, f[15:8]); put_byte(a+1, f[7:0]); put_byte(a+2, l[15:8]); put_byte(a+3, l[7:0]);
      put_byte(a+4, p[31:24]); put_byte(a+5, p[23:16]); put_byte(a+6, p[15:8]); put_byte(a+7, p[7:0]);
    end
  endtask

  function automatic logic [15:0] get_flags(input logic [31:0] a, input bit le);
    logic [8:0] i;
    i = 9'(a - 32'h100);
    return le ? {dmem[i+1], dmem[i]} : {dmem[i], dmem[i+1]};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic run_walk(input logic [31:0] rb, input logic [31:0] cp);
    int p0, t;
    p0 = npw;
    @(negedge clk);
    ring_base = rb; cur_ptr = cp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (npw == p0 && t < 20000) begin @(negedge clk); t++; end
    if (npw == p0) begin
      nchk++; nfail++;
      $display("FAIL R11: walk watchdog actual %0d expected %0d", npw, p0 + 1);
      summary();
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R4: global watchdog actual 0 expected 1");
    summary();
  end

  // {le, pad_all, pad flag on first, offload flag on first, len A, len B}
  localparam logic [19:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 8'd10, 8'd20},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'd5,  8'd7 },
    {1'b0, 1'b0, 1'b1, 1'b0, 8'd40, 8'd30},
    {1'b1, 1'b0, 1'b0, 1'b1, 8'd12, 8'd20},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'd8,  8'd4 },
    {1'b1, 1'b0, 1'b1, 1'b0, 8'd0,  8'd16}
  };

  initial begin
    for (int i = 0; i < 512; i++) dmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!tx_valid && !mem_rd && !mem_wr && !ptr_we && !frame_done && !buf_done, "R11 reset outputs idle",
        {tx_valid, mem_rd, mem_wr, ptr_we}, 0);
    chk(halt_flags == 32'h0, "R11 reset halt_flags", halt_flags, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: start with transmit disabled
    put_desc(32'h100, 16'hB800, 16'd4, 32'h1000, 1'b0);
    begin
      int r0, p0;
      r0 = nrd; p0 = npw;
      tx_en = 1'b0;
      @(negedge clk); ring_base = 32'h100; cur_ptr = 32'h100; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (40) @(negedge clk);
      chk(nrd == r0, "R3 no memory reads", nrd - r0, 0);
      chk(npw == p0 && halt_flags == 32'h0, "R3 no pointer store or halt", halt_flags, 0);
    end
    tx_en = 1'b1;

    // Table-driven single-frame walks: R1 R6 R7 R8 R9 R10 R11
    for (int v = 0; v < 6; v++) begin
      bit le, gp, dp, toe, pe, oe;
      int la, lb, tot, elen, st, o0, f0, fd0, bd0, bad;
      logic [15:0] f0l;
      logic [7:0] e;
      {le, gp, dp, toe} = VEC[v][19:16];
      la = int'(VEC[v][15:8]); lb = int'(VEC[v][7:0]);
      f0l = 16'h8000 | 16'h03BC | 16'h0040 | 16'h0400 | (dp ? 16'h4000 : 16'h0) | (toe ? 16'h0002 : 16'h0);
      desc_le = le; pad_all = gp;
      put_desc(32'h100, f0l, 16'(la), 32'h1000, le);
      put_desc(32'h108, 16'hB801, 16'(lb), 32'h2000, le);
      o0 = ocnt; f0 = nfr; fd0 = nfd; bd0 = nbd;
      run_walk(32'h100, 32'h100);
      tot = la + lb;
      pe = gp || (dp && la != 0);
      oe = toe && la != 0;
      elen = (pe && tot < 64) ? 64 : tot;
      st = oe ? 8 : 0;
      chk(nfr == f0 + 1, $sformatf("R8 vec%0d one frame", v), nfr - f0, 1);
      chk(ocnt - o0 == elen - st, $sformatf("R8 vec%0d frame length", v), ocnt - o0, elen - st);
      bad = 0;
      for (int k = st; k < elen; k++) begin
        e = (k < la) ? pat(16'(32'h1000 + k)) : (k < tot) ? pat(16'(32'h2000 + k - la)) : 8'h00;
        if (obuf[o0 + k - st] !== e) bad++;
      end
      chk(bad == 0, $sformatf("R6 R1 vec%0d frame bytes mismatches", v), bad, 0);
      chk(nfd == fd0 + 1 && nbd == bd0, $sformatf("R9 vec%0d frame_done once", v), nfd - fd0, 1);
      chk(ptr_out == 32'h100, $sformatf("R4 vec%0d final pointer", v), ptr_out, 32'h100);
      chk(halt_flags == (32'h1 << (31 - RID)), $sformatf("R11 vec%0d halt bit", v), halt_flags, 32'h1 << (31 - RID));
      chk(get_flags(32'h100, le) == (f0l & 16'h7C40), $sformatf("R10 vec%0d first write-back", v),
          get_flags(32'h100, le), f0l & 16'h7C40);
      chk(get_flags(32'h108, le) == 16'h3800, $sformatf("R10 vec%0d last write-back", v),
          get_flags(32'h108, le), 16'h3800);
    end

    // R2 R4 R5: unaligned inputs, mid-ring start, non-ready slot skipped
    desc_le = 1'b0; pad_all = 1'b0;
    put_desc(32'h200, 16'h9800, 16'd4, 32'h3000, 1'b0);
    put_desc(32'h208, 16'h03BC, 16'd9, 32'h3000, 1'b0);
    put_desc(32'h210, 16'hB800, 16'd4, 32'h3000, 1'b0);
    begin
      int o0, f0, bad;
      o0 = ocnt; f0 = nfr;
      run_walk(32'h203, 32'h20D);
      chk(nfr == f0 + 1 && ocnt - o0 == 4, "R5 only ready descriptor sent", ocnt - o0, 4);
      bad = 0;
      for (int k = 0; k < 4; k++) if (obuf[o0 + k] !== pat(16'h3000 + 16'(k))) bad++;
      chk(bad == 0, "R6 mid-ring frame bytes", bad, 0);
      chk(get_flags(32'h208, 1'b0) == 16'h03BC, "R5 non-ready not written", get_flags(32'h208, 1'b0), 16'h03BC);
      chk(get_flags(32'h200, 1'b0) == 16'h9800, "R4 slot before start untouched", get_flags(32'h200, 1'b0), 16'h9800);
      chk(ptr_out == 32'h200, "R2 aligned base as final pointer", ptr_out, 32'h200);
    end

    // R12 R7 R9 R6: two frames in one walk, options relatched, high address bits
    addr_hi = 4'h5; hi_seen = 4'h0;
    put_desc(32'h280, 16'h9000, 16'd3, 32'h4000, 1'b0);
    put_desc(32'h288, 16'h8800, 16'd2, 32'h4100, 1'b0);
    put_desc(32'h290, 16'hF800, 16'd6, 32'h4200, 1'b0);
    begin
      int o0, f0, fd0, bd0, bad;
      logic [7:0] e;
      o0 = ocnt; f0 = nfr; fd0 = nfd; bd0 = nbd;
      run_walk(32'h280, 32'h280);
      chk(nfr == f0 + 2, "R12 two frames", nfr - f0, 2);
      chk(fend[f0] - o0 == 5, "R12 first frame length", fend[f0] - o0, 5);
      chk(fend[f0 + 1] - fend[f0] == 64, "R7 second frame padded", fend[f0 + 1] - fend[f0], 64);
      bad = 0;
      for (int k = 0; k < 69; k++) begin
        e = (k < 3) ? pat(16'h4000 + 16'(k)) : (k < 5) ? pat(16'h4100 + 16'(k - 3)) :
            (k < 11) ? pat(16'h4200 + 16'(k - 5)) : 8'h00;
        if (obuf[o0 + k] !== e) bad++;
      end
      chk(bad == 0, "R12 two-frame bytes", bad, 0);
      chk(nbd == bd0 + 1 && nfd == fd0 + 1, "R9 buf_done and frame_done", {nbd - bd0, nfd - fd0}, 64'h100000001);
      chk(hi_seen == 4'h5, "R6 buffer high address bits", hi_seen, 5);
    end
    addr_hi = 4'h0;

    // R6 R9: lone zero-length last descriptor
    put_desc(32'h2C0, 16'hB800, 16'd0, 32'h5000, 1'b0);
    begin
      int o0, fd0, bd0;
      o0 = ocnt; fd0 = nfd; bd0 = nbd;
      run_walk(32'h2C0, 32'h2C0);
      chk(ocnt == o0, "R6 zero length sends nothing", ocnt - o0, 0);
      chk(nbd == bd0 + 1 && nfd == fd0, "R9 empty last gives buf_done", nbd - bd0, 1);
      chk(get_flags(32'h2C0, 1'b0) == 16'h3800, "R10 zero-length write-back", get_flags(32'h2C0, 1'b0), 16'h3800);
    end

    summary();
  end
endmodule